// File: doc/BRIEF.md
# Dock Data Latch with Staged Literal Loading

This block is the word-wide data register of a dock, placed between an inbound data port and an outbound data port. It carries out commands that a separate decoder has already decoded. A command can capture the incoming word, capture it as a flush, commit a literal, or hold. Any of these can also present the resulting latch value to the outbound port. Each port uses a simple valid/ready handshake.

Literals reach the latch in two steps. When an instruction reaches the on-deck stage, its literal is sampled into a staging register. This is either a short immediate that is sign-extended at once, or a 19-bit chunk for shifting. The data latch takes the staged value only when that instruction later executes. Repeated shift commits build a long literal 19 bits at a time, entering at the low end of the register.

A flushing indicator is stored next to the data word and travels with it to the outbound port.

Top module: `dock_literal_latch`

## Requirements
- R1: After reset the data latch is zero and its flushing indicator is clear. `out_valid` is low, `od_ready` is high and `in_ready` is low.
- R2: Capture command (`ex_op`=01):
  - It waits (`ex_ready` low) while `in_valid` is low.
  - When it executes, it loads `in_data` into the latch, clears the flushing indicator and pulses `in_ready` for that cycle.
- R3: Flush command (`ex_op`=10) behaves like capture but sets the flushing indicator. A literal commit clears the indicator. The indicator appears on `out_flush` together with the emitted word.
- R4: A sign-extend literal (`od_shift`=0) stages a 37-bit word:
  - bits [13:0] come from `od_imm[13:0]`;
  - bits [36:14] are all copies of `od_sign`;
  - `od_imm[18:14]` is ignored.
- R5: Committing a shift literal (`od_shift`=1) sets the latch to {old latch[17:0], `od_imm[18:0]`}. `od_sign` is ignored.
- R6: A literal is sampled only in the cycle it is accepted on the on-deck port. The latch keeps its old value until a literal-commit command (`ex_op`=11) executes.
- R7: While a staged literal is waiting to be committed, `od_ready` is low and no new on-deck literal is taken.
- R8: A literal-commit command waits (`ex_ready` low) while nothing is staged.
- R9: Emit (`ex_emit`=1):
  - From the cycle after execution, `out_valid` is high and `out_data` holds the latch value that results from the command. That value is held unchanged until `out_ready` is seen.
  - While `out_valid` is high, any command with `ex_emit` set waits.
- R10: A hold command (`ex_op`=00) leaves the latch and its flushing indicator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound word present |
| in_data | input | 37 | Inbound word |
| in_ready | output | 1 | Inbound word consumed this cycle |
| od_valid | input | 1 | On-deck literal present |
| od_shift | input | 1 | 1: shift chunk, 0: sign-extend literal |
| od_imm | input | 19 | Literal field |
| od_sign | input | 1 | Fill bit for sign-extend literal |
| od_ready | output | 1 | Staging register free |
| ex_valid | input | 1 | Command executing |
| ex_op | input | 2 | 00 hold, 01 capture, 10 flush, 11 commit literal |
| ex_emit | input | 1 | Also present result outbound |
| ex_ready | output | 1 | Command can complete this cycle |
| out_valid | output | 1 | Outbound word present |
| out_data | output | 37 | Outbound word |
| out_flush | output | 1 | Flushing indicator of outbound word |
| out_ready | input | 1 | Successor takes outbound word |

## Verification
The hardest situation to reach is a staged literal that sits uncommitted while a second on-deck literal is offered and the execute side issues other commands in between. In that state the latch must still read its old value, and the staged value must not be overwritten. The bench stages one literal, then holds a different literal on the on-deck port for several cycles, reads the latch with a hold-and-emit, and only then commits. The bench also builds long values by sweeping chains of shift chunks over several starting words, and computes each expected word as a shift-and-or on 37-bit arithmetic.

// File: rtl/dock_literal_latch.sv
module dock_literal_latch #(
  parameter int WORD_W  = 37,
  parameter int SHIFT_W = 19,
  parameter int SEXT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              od_valid,
  input  logic              od_shift,
  input  logic [SHIFT_W-1:0] od_imm,
  input  logic              od_sign,
  output logic              od_ready,
  input  logic              ex_valid,
  input  logic [1:0]        ex_op,
  input  logic              ex_emit,
  output logic              ex_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_flush,
  input  logic              out_ready
);
  localparam int KEEP_W = WORD_W - SHIFT_W;
  localparam logic [1:0] OP_HOLD = 2'b00, OP_CAP = 2'b01, OP_FLUSH = 2'b10, OP_LIT = 2'b11;

  logic              stg_full, stg_shift;
  logic [WORD_W-1:0] stg_word, dl_word, nxt_word;
  logic              dl_flush, nxt_flush;

  wire need_in  = (ex_op == OP_CAP) || (ex_op == OP_FLUSH);
  wire need_lit = (ex_op == OP_LIT);
  wire fire     = ex_valid && ex_ready;

  assign ex_ready = (!need_in || in_valid) && (!need_lit || stg_full) && (!ex_emit || !out_valid);
  assign in_ready = fire && need_in;
  assign od_ready = !stg_full;

  always_comb begin
    nxt_word  = dl_word;
    nxt_flush = dl_flush;
    case (ex_op)
      OP_CAP:   begin nxt_word = in_data; nxt_flush = 1'b0; end
      OP_FLUSH: begin nxt_word = in_data; nxt_flush = 1'b1; end
      OP_LIT:   begin
        nxt_flush = 1'b0;
        nxt_word  = stg_shift ? {dl_word[KEEP_W-1:0], stg_word[SHIFT_W-1:0]} : stg_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_full  <= 1'b0;
      stg_shift <= 1'b0;
      stg_word  <= '0;
    end else if (fire && need_lit) begin
      stg_full <= 1'b0;
    end else if (od_valid && !stg_full) begin
      stg_full  <= 1'b1;
      stg_shift <= od_shift;
      stg_word  <= od_shift ? WORD_W'(od_imm)
                            : {{(WORD_W-SEXT_W){od_sign}}, od_imm[SEXT_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_word  <= '0;
      dl_flush <= 1'b0;
    end else if (fire) begin
      dl_word  <= nxt_word;
      dl_flush <= nxt_flush;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flush <= 1'b0;
    end else if (fire && ex_emit) begin
      out_valid <= 1'b1;
      out_data  <= nxt_word;
      out_flush <= nxt_flush;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dock_literal_latch_chk.sv
module dock_literal_latch_chk #(
  parameter int WORD_W  = 37,
  parameter int SHIFT_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic              in_ready,
  input logic              od_valid,
  input logic              od_ready,
  input logic              ex_valid,
  input logic [1:0]        ex_op,
  input logic              ex_emit,
  input logic              ex_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_flush,
  input logic              out_ready
);
  a_r2_drain_only_present: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  a_r2_capture_emits_input: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && ex_op == 2'b01 && ex_emit) |=> (out_data == $past(in_data)) && !out_flush);

  a_r3_flush_marks_output: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && ex_op == 2'b10 && ex_emit) |=> out_flush && out_valid);

  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (od_valid && od_ready) |=> !od_ready);

  a_r8_commit_needs_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == 2'b11 && od_ready) |-> !ex_ready);

  a_r9_output_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_flush));

  a_r9_emit_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_emit && out_valid) |-> !ex_ready);
endmodule

bind dock_literal_latch dock_literal_latch_chk #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_chk (.*);

// File: tb/tb_dock_literal_latch.sv
`timescale 1ns/1ps
module tb_dock_literal_latch;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, od_valid = 0, od_shift = 0, od_sign = 0;
  logic ex_valid = 0, ex_emit = 0, out_ready = 0;
  logic [36:0] in_data = '0;
  logic [18:0] od_imm = '0;
  logic [1:0]  ex_op = 2'b00;
  logic in_ready, od_ready, ex_ready, out_valid, out_flush;
  logic [36:0] out_data;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit saw_in_ready;

  always #2 clk = ~clk;

  dock_literal_latch dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic exec(input logic [1:0] op, input logic emit);
    @(negedge clk);
    ex_valid = 1; ex_op = op; ex_emit = emit;
    #0.5;
    while (!ex_ready) begin @(negedge clk); #0.5; end
    saw_in_ready = in_ready;
    @(posedge clk); #1;
    ex_valid = 0; ex_emit = 0; ex_op = 2'b00;
  endtask

  task automatic stage(input logic sh, input logic [18:0] imm, input logic sg);
    @(negedge clk);
    od_valid = 1; od_shift = sh; od_imm = imm; od_sign = sg;
    #0.5;
    while (!od_ready) begin @(negedge clk); #0.5; end
    @(posedge clk); #1;
    od_valid = 0; od_imm = 19'h5a5a5; od_sign = ~sg;
  endtask

  task automatic capture(input logic [36:0] w, input logic fl, input string tag);
    @(negedge clk);
    in_valid = 1; in_data = w;
    exec(fl ? 2'b10 : 2'b01, 1'b0);
    chk(saw_in_ready, tag, {63'd0, saw_in_ready}, 64'd1);
    in_valid = 0; in_data = ~w;
  endtask

  task automatic read(input logic [36:0] exp, input logic fl, input string tag);
    exec(2'b00, 1'b1);
    chk(out_valid && out_data == exp && out_flush == fl, tag,
        {26'd0, out_flush, out_data}, {26'd0, fl, exp});
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  function automatic logic [36:0] sext(input logic [13:0] imm, input logic s);
    logic [36:0] e = 37'(imm);
    if (s) e = e - (37'd1 << 14);
    return e;
  endfunction

  initial begin
    logic [36:0] exp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!out_valid && od_ready && !in_ready, "R1", {61'd0, out_valid, od_ready, in_ready}, 64'b010);
    read(37'd0, 1'b0, "R1");

    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 16; k++) begin
        logic [18:0] imm = 19'((k * 14'h1357) ^ (k << 15)) ^ 19'(k << 14);
        stage(1'b0, imm, s[0]);
        exec(2'b11, 1'b0);
        read(sext(imm[13:0], s[0]), 1'b0, "R4");
      end

    for (int st = 0; st < 4; st++) begin
      exp = sext(14'(st * 14'h0a3f), st[0]);
      stage(1'b0, 19'(st * 14'h0a3f), st[0]);
      exec(2'b11, 1'b0);
      for (int k = 0; k < 3; k++) begin
        logic [18:0] ch = 19'(st * 19'h2f1d3 + k * 19'h1b6e5);
        stage(1'b1, ch, k[0]);
        exec(2'b11, 1'b0);
        exp = (exp << 19) | 37'(ch);
        read(exp, 1'b0, "R5");
      end
    end

    for (int k = 0; k < 6; k++) begin
      logic [36:0] w = 37'(64'h1f2e3d4c5b * (k + 1));
      capture(w, k[0], k[0] ? "R3" : "R2");
      read(w, k[0], k[0] ? "R3" : "R2");
    end
    stage(1'b0, 19'h00123, 1'b0);
    exec(2'b11, 1'b0);
    read(37'h123, 1'b0, "R3");

    @(negedge clk);
    ex_valid = 1; ex_op = 2'b01; #0.5;
    chk(!ex_ready && !in_ready, "R2", {62'd0, ex_ready, in_ready}, 64'd0);
    @(negedge clk); ex_valid = 0;
    @(negedge clk);
    ex_valid = 1; ex_op = 2'b11; #0.5;
    chk(!ex_ready, "R8", {63'd0, ex_ready}, 64'd0);
    @(negedge clk); ex_valid = 0; ex_op = 2'b00;

    stage(1'b0, 19'h01abc, 1'b1);
    @(negedge clk);
    od_valid = 1; od_shift = 1; od_imm = 19'h7ffff;
    for (int k = 0; k < 3; k++) begin
      #0.5 chk(!od_ready, "R7", {63'd0, od_ready}, 64'd0);
      @(negedge clk);
    end
    od_valid = 0;
    read(37'h123, 1'b0, "R6");
    exec(2'b11, 1'b0);
    read(sext(14'h1abc, 1'b1), 1'b0, "R6");
    @(negedge clk);
    chk(od_ready, "R7", {63'd0, od_ready}, 64'd1);

    capture(37'h0_dead_beef, 1'b1, "R10");
    repeat (3) exec(2'b00, 1'b0);
    read(37'h0_dead_beef, 1'b1, "R10");

    exec(2'b00, 1'b1);
    exp = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == 37'h0_dead_beef, "R9", {27'd0, out_data}, {27'd0, 37'h0_dead_beef});
    end
    ex_valid = 1; ex_op = 2'b00; ex_emit = 1; #0.5;
    chk(!ex_ready, "R9", {63'd0, ex_ready}, 64'd0);
    @(negedge clk); ex_valid = 0; ex_emit = 0;
    out_ready = 1; @(posedge clk); #1 out_ready = 0;
    chk(!out_valid, "R9", {63'd0, out_valid}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule